// File: doc/BRIEF.md
# Channel Completion Flag Bank

This block keeps one sticky completion flag per coprocessor channel, 128 channels by default. When a channel's thread finishes, the coprocessor raises that channel's flag through an internal set port by naming the channel number. A host reads the flags and clears them over a small 16-bit register bus. It clears a flag by writing a one to the matching bit. Writing zero to a bit leaves that flag alone.

The flags are packed sixteen to a register into eight registers at word addresses 0x05 to 0x0C. The registers run in descending order. The highest channel group sits at the lowest address, and the register at 0x0C carries channels 15..0. The block also drives the full flag vector and a single interrupt line. That line is the registered OR of all flags.

The set port carries data into the block but is never back-pressured: a valid strobe is taken on the same clock edge, so it needs no ready signal. The host bus is a single-outstanding strobe/acknowledge interface, and the acknowledge comes one cycle after the strobe is accepted.

Top module: `ifb_flag_bank`

## Requirements
- R1: While and after `rst_n` is low, every flag, `flag_vec`, `irq`, `bus_ack` and `bus_rdata` are zero.
- R2: A clock edge with `set_valid` high sets the flag of channel `set_chan` and changes no other flag.
- R3: Register address 0x0C-k (k = 0..7) reads channels 16k+15..16k, with bit n of the word being channel 16k+n. So 0x0C holds channels 15..0 and 0x05 holds channels 127..112.
- R4: An accepted host write to a flag address clears each flag whose data bit is 1 and keeps each flag whose data bit is 0.
- R5: If a set and a host clear target the same flag on the same edge, the flag ends set.
- R6: `irq` equals the OR of all flags as they were one cycle earlier.
- R7: A strobe is accepted when `bus_req` is high and `bus_ack` is low. `bus_ack` is high for exactly the cycle after each accepted strobe, for both reads and writes. A strobe that is held therefore gets an acknowledge every other cycle.
- R8: A read of an address outside 0x05..0x0C returns zero, and a write to such an address changes no flag.
- R9: `flag_vec` bit i is the flag of channel i, updated on the edge that sets or clears it.
- R10: Read data appears on `bus_rdata` together with `bus_ack` and shows the flags as they were before the accepting edge. `bus_rdata` is zero in every other cycle and after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Set strobe from the coprocessor, always accepted |
| set_chan | input | 7 | Channel whose flag is set |
| bus_req | input | 1 | Host strobe |
| bus_we | input | 1 | Host write (1) or read (0) |
| bus_addr | input | 5 | Host word address |
| bus_wdata | input | 16 | Host write data, ones clear flags |
| bus_rdata | output | 16 | Host read data, valid with bus_ack |
| bus_ack | output | 1 | Host acknowledge |
| flag_vec | output | 128 | All flags, bit i = channel i |
| irq | output | 1 | Registered OR of all flags |

## Verification
A flag that is wrong inside the bank shows on `flag_vec` on the same edge and on `irq` one cycle later. It also shows in the next read of its register. Because of that, a reference model compared every clock catches a lost set, a missed clear or a clear of the wrong bit within one cycle. An error in the address decode, such as a reversed group order or a missing out-of-range guard, only shows when that address is read or written. For that reason the random traffic covers every flag address and addresses on both sides of the range. Acknowledge faults show in the cycle right after the strobe.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int unsigned IFB_DATA_W    = 16;
  localparam int unsigned IFB_ADDR_W    = 5;
  localparam int unsigned IFB_NUM_CHAN  = 128;
  localparam int unsigned IFB_BASE_ADDR = 5;

  typedef enum logic {
    HOST_RD = 1'b0,
    HOST_WR = 1'b1
  } host_op_e;
endpackage

// File: rtl/ifb_addr_dec.sv
module ifb_addr_dec #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BASE_ADDR = 5
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] grp_sel,
  output logic                hit
);
  // Descending map: the top address of the window holds group 0
  localparam int unsigned TOP_ADDR = BASE_ADDR + NUM_REGS - 1;

  always_comb begin
    for (int g = 0; g < NUM_REGS; g++) begin
      grp_sel[g] = (addr == ADDR_W'(TOP_ADDR - g));
    end
    hit = |grp_sel;
  end
endmodule

// File: rtl/ifb_flag_group.sv
module ifb_flag_group #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned CHAN_W = 7,
  parameter int unsigned GRP    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [CHAN_W-1:0] set_chan,
  input  logic              clr_en,
  input  logic [WIDTH-1:0]  clr_bits,
  output logic [WIDTH-1:0]  flags
);
  localparam int unsigned LW = $clog2(WIDTH);
  localparam int unsigned HW = CHAN_W - LW;

  logic [WIDTH-1:0] set_mask;
  logic [WIDTH-1:0] clr_mask;

  always_comb begin
    set_mask = '0;
    if (set_valid && (set_chan[CHAN_W-1:LW] == HW'(GRP))) begin
      set_mask[set_chan[LW-1:0]] = 1'b1;
    end
    clr_mask = clr_en ? clr_bits : '0;
  end

  // Set is or-ed in after the clear so a coinciding event survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((flags & $past(set_mask)) == $past(set_mask))); // R2
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & clr_mask) != '0) |=> ((flags & $past(set_mask & clr_mask)) != '0)); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((flags & $past(clr_mask & ~set_mask)) == '0)); // R4
  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(clr_mask | set_mask)) == '0)); // R4
endmodule

// File: rtl/ifb_host_port.sv
module ifb_host_port #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BASE_ADDR = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [NUM_REGS*DATA_W-1:0] grp_rd,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_ack,
  output logic [NUM_REGS-1:0]        clr_sel,
  output logic [DATA_W-1:0]          clr_bits,
  output logic                       wr_miss
);
  import ifb_pkg::*;

  logic [NUM_REGS-1:0] grp_sel;
  logic                hit;
  logic                accept;
  host_op_e            op;
  logic [DATA_W-1:0]   rd_word;

  ifb_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr   (bus_addr),
    .grp_sel(grp_sel),
    .hit    (hit)
  );

  assign accept = bus_req && !bus_ack;
  assign op     = bus_we ? HOST_WR : HOST_RD;

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NUM_REGS; g++) begin
      rd_word |= grp_sel[g] ? grp_rd[g*DATA_W +: DATA_W] : '0;
    end
    clr_sel  = (accept && op == HOST_WR) ? grp_sel : '0;
    clr_bits = bus_wdata;
    wr_miss  = accept && (op == HOST_WR) && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= accept;
      bus_rdata <= (accept && op == HOST_RD) ? rd_word : '0;
    end
  end

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_ack); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R7
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0)); // R10
endmodule

// File: rtl/ifb_flag_bank.sv
module ifb_flag_bank #(
  parameter int unsigned NUM_CHAN  = ifb_pkg::IFB_NUM_CHAN,
  parameter int unsigned DATA_W    = ifb_pkg::IFB_DATA_W,
  parameter int unsigned ADDR_W    = ifb_pkg::IFB_ADDR_W,
  parameter int unsigned BASE_ADDR = ifb_pkg::IFB_BASE_ADDR,
  localparam int unsigned CHAN_W   = $clog2(NUM_CHAN),
  localparam int unsigned NUM_REGS = NUM_CHAN / DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_valid,
  input  logic [CHAN_W-1:0]   set_chan,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_ack,
  output logic [NUM_CHAN-1:0] flag_vec,
  output logic                irq
);
  logic [NUM_REGS-1:0] clr_sel;
  logic [DATA_W-1:0]   clr_bits;
  logic                wr_miss;

  ifb_host_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .grp_rd   (flag_vec),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack),
    .clr_sel  (clr_sel),
    .clr_bits (clr_bits),
    .wr_miss  (wr_miss)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_grp
    ifb_flag_group #(
      .WIDTH (DATA_W),
      .CHAN_W(CHAN_W),
      .GRP   (g)
    ) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_valid(set_valid),
      .set_chan (set_chan),
      .clr_en   (clr_sel[g]),
      .clr_bits (clr_bits),
      .flags    (flag_vec[g*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |flag_vec;
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vec != '0) |=> irq); // R6
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vec == '0) |=> !irq); // R6
  AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_miss && !set_valid) |=> $stable(flag_vec)); // R8
endmodule

// File: tb/ifb_flag_bank_bench.sv
module ifb_flag_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         set_valid = 1'b0;
  logic [6:0]   set_chan = '0;
  logic         bus_req = 1'b0;
  logic         bus_we = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic [15:0]  bus_rdata;
  logic         bus_ack;
  logic [127:0] flag_vec;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ifb_flag_bank u_ifb_flag_bank (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_chan(set_chan),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .flag_vec(flag_vec), .irq(irq)
  );

  // Behavioural reference model
  logic [127:0] m_flags;
  logic         m_irq, m_ack;
  logic [15:0]  m_rdata;

  function automatic logic [15:0] m_read(input logic [127:0] f, input int a);
    if (a >= 5 && a <= 12) return f[(12 - a)*16 +: 16];
    return 16'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_irq = 0; m_ack = 0; m_rdata = '0;
    end else begin
      logic [127:0] clr;
      logic         acc;
      clr = '0;
      acc = bus_req && !m_ack;
      m_rdata = '0;
      if (acc && bus_we && bus_addr >= 5 && bus_addr <= 12)
        clr[(12 - int'(bus_addr))*16 +: 16] = bus_wdata;
      if (acc && !bus_we) m_rdata = m_read(m_flags, int'(bus_addr));
      m_irq = (m_flags != '0);
      m_flags = m_flags & ~clr;
      if (set_valid) m_flags[set_chan] = 1'b1;
      m_ack = acc;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(flag_vec == m_flags, "R9 flag_vec (R2)", flag_vec, m_flags);
      check(irq == m_irq, "R6 irq", 128'(irq), 128'(m_irq));
      check(bus_ack == m_ack, "R7 bus_ack", 128'(bus_ack), 128'(m_ack));
      check(bus_rdata == m_rdata, "R10 bus_rdata (R3)", 128'(bus_rdata), 128'(m_rdata));
    end
  end

  task automatic host_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic host_read_chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    check(bus_ack && bus_rdata == exp, tag, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic set_one(input logic [6:0] c);
    @(negedge clk);
    set_valid = 1; set_chan = c;
    @(negedge clk);
    set_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(flag_vec == '0 && !irq && !bus_ack && bus_rdata == '0, "R1 reset state",
          flag_vec, 128'h0);
    rst_n = 1;
    @(negedge clk);
    check(flag_vec == '0 && !irq, "R1 after release", flag_vec, 128'h0);

    set_one(7'd1);
    set_one(7'd9);
    host_read_chk(5'h0C, 16'h0202, "R3 low group channels 1,9");
    set_one(7'd127);
    host_read_chk(5'h05, 16'h8000, "R3 top group channel 127");
    check(flag_vec[127] && flag_vec[1] && flag_vec[9], "R9 vector bit positions",
          flag_vec, 128'h0);
    check(irq, "R6 irq high with flags set", 128'(irq), 128'h1);

    host_write(5'h0C, 16'h0002);
    host_read_chk(5'h0C, 16'h0200, "R4 write-one clears channel 1 only");

    host_read_chk(5'h04, 16'h0000, "R8 read below range");
    host_read_chk(5'h0D, 16'h0000, "R8 read above range");
    host_write(5'h0D, 16'hFFFF);
    host_write(5'h04, 16'hFFFF);
    host_read_chk(5'h05, 16'h8000, "R8 miss writes leave flags");

    // Set channel 20 on the same edge as a clear of it (0x0B bit 4)
    @(negedge clk);
    set_valid = 1; set_chan = 7'd20;
    bus_req = 1; bus_we = 1; bus_addr = 5'h0B; bus_wdata = 16'h0010;
    @(negedge clk);
    set_valid = 0; bus_req = 0; bus_we = 0;
    host_read_chk(5'h0B, 16'h0010, "R5 set beats clear");

    // Held strobe: ack pattern 1,0,1
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 5'h0C;
    @(negedge clk); check(bus_ack, "R7 held strobe ack 1", 128'(bus_ack), 128'h1);
    @(negedge clk); check(!bus_ack, "R7 held strobe gap", 128'(bus_ack), 128'h0);
    @(negedge clk); check(bus_ack, "R7 held strobe ack 2", 128'(bus_ack), 128'h1);
    bus_req = 0;

    for (int a = 5; a <= 12; a++) host_write(5'(a), 16'hFFFF);
    @(negedge clk);
    check(flag_vec == '0 && !irq, "R6 irq low after all cleared", 128'(irq), 128'h0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      set_valid = ($urandom_range(0, 1) == 1);
      set_chan  = 7'($urandom_range(0, 127));
      bus_req   = ($urandom_range(0, 2) != 0);
      bus_we    = ($urandom_range(0, 1) == 1);
      bus_addr  = 5'($urandom_range(3, 14));
      bus_wdata = 16'($urandom);
    end
    @(negedge clk);
    set_valid = 0; bus_req = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule